// File: doc/BRIEF.md
# Processor Bus Release and Halt Controller

This block decides, cycle by cycle, whether an 8-bit processor core drives its external address bus, data bus and read/write line, or lets them float so that another master can use them. Two requests can take the buses away. A halt request lets the current instruction run to its end before the buses are released. A bus request for direct memory access is granted almost at once and freezes the core clock. The controller also reports its condition on a two-bit status code.

While the bus is granted for direct memory access, the core's dynamic registers need a refresh. After a fixed number of granted cycles the controller therefore takes the buses back for a single refresh cycle, and then releases them again. During internal processing cycles, and during those refresh cycles, the address output is forced to all ones and the read/write line shows a read. All outputs come from registers. A request sampled at one clock edge changes the outputs at that same edge.

Top module: `bus_release_ctrl`

## Requirements
- R1: With `halt_n` low and no bus request, the buses stay driven until a cycle in which `instr_end` is high is sampled. From the next edge on the controller is halted and stays halted while `halt_n` stays low. Raising `halt_n` before that cycle cancels the pending halt.
- R2: `addr_oe`, `data_oe` and `rw_oe` always carry the same value. It is 0 while halted or while the bus is granted, and 1 in all other cycles (including reset and the refresh cycle).
- R3: `int_block` is 1 exactly while halted. While halted, `clk_freeze` is 0, so the core clocks keep running.
- R4: A bus request sampled low at edge k, from a running or halted state, sets `clk_freeze` at edge k with the buses still driven. It floats the buses and gives status 11 at edge k+1. It does not wait for `instr_end`.
- R5: While the bus is granted, `clk_freeze` is 1. After STEAL_PERIOD (default 14) consecutive granted cycles, the controller inserts one refresh cycle. In that cycle the buses are driven, `addr_out` is all ones, `rw_out` is 1, `clk_freeze` is 0 and the status is 00. Then the grant resumes with a fresh count if the request is still low.
- R6: While the buses are driven outside a refresh cycle, `addr_out` and `rw_out` register `core_addr` and `core_rw`. When `idle_cycle` is high they register all ones and 1 (read) instead. While floated, they hold all ones and 1.
- R7: `{ba,bs}` is 11 while halted or granted, and 00 in a refresh cycle. Otherwise it is 01 when `intr_busy` is high, else 10 when `sync_wait` is high, else 00. The interrupt code has priority over the sync code.
- R8: When `halt_n` and `dma_req_n` are both low, the bus request wins. The controller enters the grant path of R4, and `int_block` stays 0.
- R9: When `dma_req_n` is sampled high during a grant, wait or refresh cycle, the buses are driven at that same edge, `clk_freeze` falls, and the status follows the running encoding of R7.
- R10: While `rst_n` is low, the buses are driven, `addr_out` is all ones, `rw_out` is 1, `clk_freeze` and `int_block` are 0, and the status is 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cycle clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_n | input | 1 | Active-low halt request |
| dma_req_n | input | 1 | Active-low bus request for direct memory access |
| instr_end | input | 1 | High in the last cycle of an instruction |
| idle_cycle | input | 1 | Core is doing an internal processing cycle |
| intr_busy | input | 1 | Interrupt entry or reset sequence in progress |
| sync_wait | input | 1 | Core is waiting in a software sync |
| core_addr | input | ADDR_W | Address from the core sequencer |
| core_rw | input | 1 | Read/write from the core, 1 = read |
| addr_out | output | ADDR_W | Registered address toward the pins |
| rw_out | output | 1 | Registered read/write toward the pins |
| addr_oe | output | 1 | Address bus driver enable |
| data_oe | output | 1 | Data bus driver enable |
| rw_oe | output | 1 | Read/write driver enable |
| clk_freeze | output | 1 | Freezes the core clock |
| int_block | output | 1 | Stops external interrupts from being serviced |
| ba | output | 1 | Status bit, high half |
| bs | output | 1 | Status bit, low half |

## Verification
The bench aims at the refresh cycle that cuts into a long grant, and at the 14th granted cycle in particular. A counter that is off by one would steal one cycle too early or too late, and a controller that leaves the buses floated during the steal would starve the refresh. It holds a halt request across many cycles without an end-of-instruction strobe. A controller that does not wait would float the buses in the middle of an instruction. It raises halt and bus requests together and checks that the grant path, with its frozen clock, wins. It also raises a bus request while halted and releases it, where a wrong design would report the wrong status code or keep the buses floated a cycle too long.

// File: rtl/brc_pkg.sv
`timescale 1ns/1ps
package brc_pkg;

    typedef enum logic [2:0] {
        ST_RUN     = 3'd0,
        ST_HPEND   = 3'd1,
        ST_HALTED  = 3'd2,
        ST_DWAIT   = 3'd3,
        ST_GRANT   = 3'd4,
        ST_REFRESH = 3'd5
    } brc_state_e;

    typedef enum logic [1:0] {
        BS_RUN  = 2'b00,
        BS_INTR = 2'b01,
        BS_SYNC = 2'b10,
        BS_OFF  = 2'b11
    } bus_status_e;

    function automatic logic is_dma_path(input brc_state_e s);
        return (s == ST_DWAIT) || (s == ST_GRANT) || (s == ST_REFRESH);
    endfunction

endpackage

// File: rtl/brc_arbiter.sv
`timescale 1ns/1ps
module brc_arbiter
    import brc_pkg::*;
#(
    parameter int STEAL_PERIOD = 14,
    parameter int CNT_W        = $clog2(STEAL_PERIOD)
) (
    input  brc_state_e       state_q,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic             halt_req,
    input  logic             dma_req,
    input  logic             instr_end,
    output brc_state_e       state_d,
    output logic [CNT_W-1:0] cnt_d
);
    localparam logic [CNT_W-1:0] LAST_GRANT = CNT_W'(STEAL_PERIOD - 1);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (is_dma_path(state_q)) begin
            if (!dma_req) begin
                state_d = ST_RUN;
                cnt_d   = '0;
            end else begin
                unique case (state_q)
                    ST_DWAIT: begin
                        state_d = ST_GRANT;
                        cnt_d   = '0;
                    end
                    ST_GRANT: begin
                        if (cnt_q == LAST_GRANT) begin
                            state_d = ST_REFRESH;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                    default: begin
                        state_d = ST_GRANT;
                        cnt_d   = '0;
                    end
                endcase
            end
        end else begin
            cnt_d = '0;
            if (dma_req) begin
                state_d = ST_DWAIT;
            end else if (halt_req) begin
                if (state_q == ST_HALTED || instr_end) state_d = ST_HALTED;
                else                                   state_d = ST_HPEND;
            end else begin
                state_d = ST_RUN;
            end
        end
    end
endmodule

// File: rtl/brc_status_enc.sv
`timescale 1ns/1ps
module brc_status_enc
    import brc_pkg::*;
(
    input  brc_state_e  state_d,
    input  logic        intr_busy,
    input  logic        sync_wait,
    output bus_status_e status_d
);
    always_comb begin
        unique case (state_d)
            ST_HALTED, ST_GRANT: status_d = BS_OFF;
            ST_REFRESH:          status_d = BS_RUN;
            default: begin
                if (intr_busy)      status_d = BS_INTR;
                else if (sync_wait) status_d = BS_SYNC;
                else                status_d = BS_RUN;
            end
        endcase
    end
endmodule

// File: rtl/brc_drive.sv
`timescale 1ns/1ps
module brc_drive
    import brc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  brc_state_e        state_d,
    input  logic              idle_cycle,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic              core_rw,
    output logic              drive_d,
    output logic [ADDR_W-1:0] addr_d,
    output logic              rw_d,
    output logic              freeze_d,
    output logic              intblk_d
);
    always_comb begin
        drive_d  = !(state_d == ST_HALTED || state_d == ST_GRANT);
        freeze_d = (state_d == ST_DWAIT) || (state_d == ST_GRANT);
        intblk_d = (state_d == ST_HALTED);
        if (!drive_d || state_d == ST_REFRESH || idle_cycle) begin
            addr_d = '1;
            rw_d   = 1'b1;
        end else begin
            addr_d = core_addr;
            rw_d   = core_rw;
        end
    end
endmodule

// File: rtl/bus_release_ctrl.sv
`timescale 1ns/1ps
module bus_release_ctrl
    import brc_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int STEAL_PERIOD = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_n,
    input  logic              dma_req_n,
    input  logic              instr_end,
    input  logic              idle_cycle,
    input  logic              intr_busy,
    input  logic              sync_wait,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic              core_rw,
    output logic [ADDR_W-1:0] addr_out,
    output logic              rw_out,
    output logic              addr_oe,
    output logic              data_oe,
    output logic              rw_oe,
    output logic              clk_freeze,
    output logic              int_block,
    output logic              ba,
    output logic              bs
);
    localparam int CNT_W = (STEAL_PERIOD > 1) ? $clog2(STEAL_PERIOD) : 1;

    typedef struct packed {
        brc_state_e        state;
        logic [CNT_W-1:0]  cnt;
        bus_status_e       status;
        logic              drive;
        logic [ADDR_W-1:0] addr;
        logic              rw;
        logic              freeze;
        logic              intblk;
    } brc_regs_t;

    brc_regs_t r_q, r_d;

    brc_state_e        state_nx;
    logic [CNT_W-1:0]  cnt_nx;
    bus_status_e       status_nx;
    logic              drive_nx, rw_nx, freeze_nx, intblk_nx;
    logic [ADDR_W-1:0] addr_nx;

    brc_arbiter #(.STEAL_PERIOD(STEAL_PERIOD), .CNT_W(CNT_W)) u_arb (
        .state_q   (r_q.state),
        .cnt_q     (r_q.cnt),
        .halt_req  (!halt_n),
        .dma_req   (!dma_req_n),
        .instr_end (instr_end),
        .state_d   (state_nx),
        .cnt_d     (cnt_nx)
    );

    brc_status_enc u_stat (
        .state_d   (state_nx),
        .intr_busy (intr_busy),
        .sync_wait (sync_wait),
        .status_d  (status_nx)
    );

    brc_drive #(.ADDR_W(ADDR_W)) u_drv (
        .state_d    (state_nx),
        .idle_cycle (idle_cycle),
        .core_addr  (core_addr),
        .core_rw    (core_rw),
        .drive_d    (drive_nx),
        .addr_d     (addr_nx),
        .rw_d       (rw_nx),
        .freeze_d   (freeze_nx),
        .intblk_d   (intblk_nx)
    );

    always_comb begin
        r_d        = r_q;
        r_d.state  = state_nx;
        r_d.cnt    = cnt_nx;
        r_d.status = status_nx;
        r_d.drive  = drive_nx;
        r_d.addr   = addr_nx;
        r_d.rw     = rw_nx;
        r_d.freeze = freeze_nx;
        r_d.intblk = intblk_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state  <= ST_RUN;
            r_q.cnt    <= '0;
            r_q.status <= BS_INTR;
            r_q.drive  <= 1'b1;
            r_q.addr   <= '1;
            r_q.rw     <= 1'b1;
            r_q.freeze <= 1'b0;
            r_q.intblk <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign addr_out   = r_q.addr;
    assign rw_out     = r_q.rw;
    assign addr_oe    = r_q.drive;
    assign data_oe    = r_q.drive;
    assign rw_oe      = r_q.drive;
    assign clk_freeze = r_q.freeze;
    assign int_block  = r_q.intblk;
    assign ba         = r_q.status[1];
    assign bs         = r_q.status[0];
endmodule

// File: rtl/brc_checker.sv
`timescale 1ns/1ps
module brc_checker #(
    parameter int ADDR_W       = 16,
    parameter int STEAL_PERIOD = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              halt_n,
    input logic              dma_req_n,
    input logic              instr_end,
    input logic              idle_cycle,
    input logic [ADDR_W-1:0] addr_out,
    input logic              rw_out,
    input logic              addr_oe,
    input logic              data_oe,
    input logic              rw_oe,
    input logic              clk_freeze,
    input logic              int_block,
    input logic              ba,
    input logic              bs
);
    localparam int RUN_W = $clog2(STEAL_PERIOD + 2);
    logic [RUN_W-1:0] grant_run;

    always_ff @(posedge clk) begin
        if (!rst_n)                     grant_run <= '0;
        else if (!addr_oe && clk_freeze) grant_run <= grant_run + 1'b1;
        else                            grant_run <= '0;
    end

    p_enables_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_oe == data_oe) && (addr_oe == rw_oe));

    p_halt_waits_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_oe && dma_req_n && !instr_end) |=> addr_oe);

    p_intblk_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int_block |-> (!addr_oe && !clk_freeze));

    p_freeze_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_oe && !int_block) |-> clk_freeze);

    p_steal_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        grant_run <= RUN_W'(STEAL_PERIOD));

    p_idle_ffff_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(idle_cycle) && addr_oe) |-> (addr_out == '1 && rw_out));

    p_float_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_oe |-> ({ba, bs} == 2'b11));

    p_dma_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_req_n && !halt_n && addr_oe && !clk_freeze) |=> (clk_freeze && !int_block));

    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_oe && !int_block && dma_req_n) |=> (addr_oe && !clk_freeze));
endmodule

bind bus_release_ctrl brc_checker #(.ADDR_W(ADDR_W), .STEAL_PERIOD(STEAL_PERIOD)) u_brc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .halt_n     (halt_n),
    .dma_req_n  (dma_req_n),
    .instr_end  (instr_end),
    .idle_cycle (idle_cycle),
    .addr_out   (addr_out),
    .rw_out     (rw_out),
    .addr_oe    (addr_oe),
    .data_oe    (data_oe),
    .rw_oe      (rw_oe),
    .clk_freeze (clk_freeze),
    .int_block  (int_block),
    .ba         (ba),
    .bs         (bs)
);

// File: tb/bus_release_ctrl_test.sv
`timescale 1ns/1ps
module bus_release_ctrl_test;
    localparam int AW = 16;
    localparam int SP = 14;

    logic clk = 1'b0;
    logic rst_n, halt_n, dma_req_n, instr_end, idle_cycle, intr_busy, sync_wait, core_rw;
    logic [AW-1:0] core_addr;
    logic [AW-1:0] addr_out;
    logic rw_out, addr_oe, data_oe, rw_oe, clk_freeze, int_block, ba, bs;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // behavioural reference: 0 run,1 halt pending,2 halted,3 dma wait,4 granted,5 refresh
    int mode = 0;
    int gcnt = 0;
    bit e_drive = 1, e_rw = 1, e_freeze = 0, e_intblk = 0;
    logic [AW-1:0] e_addr = '1;
    logic [1:0] e_stat = 2'b01;

    always #2.5 clk = ~clk;

    bus_release_ctrl #(.ADDR_W(AW), .STEAL_PERIOD(SP)) uut (
        .clk(clk), .rst_n(rst_n), .halt_n(halt_n), .dma_req_n(dma_req_n),
        .instr_end(instr_end), .idle_cycle(idle_cycle), .intr_busy(intr_busy),
        .sync_wait(sync_wait), .core_addr(core_addr), .core_rw(core_rw),
        .addr_out(addr_out), .rw_out(rw_out), .addr_oe(addr_oe), .data_oe(data_oe),
        .rw_oe(rw_oe), .clk_freeze(clk_freeze), .int_block(int_block), .ba(ba), .bs(bs)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        int nm;
        if (!rst_n) begin
            mode = 0; gcnt = 0;
            e_drive = 1; e_addr = '1; e_rw = 1; e_stat = 2'b01; e_freeze = 0; e_intblk = 0;
            return;
        end
        nm = mode;
        if (mode >= 3) begin
            if (dma_req_n) begin nm = 0; gcnt = 0; end
            else if (mode == 4) begin
                if (gcnt == SP - 1) begin nm = 5; gcnt = 0; end
                else gcnt++;
            end else begin nm = 4; gcnt = 0; end
        end else begin
            gcnt = 0;
            if (!dma_req_n) nm = 3;
            else if (!halt_n) nm = (mode == 2 || instr_end) ? 2 : 1;
            else nm = 0;
        end
        mode = nm;
        e_drive  = !(nm == 2 || nm == 4);
        e_freeze = (nm == 3 || nm == 4);
        e_intblk = (nm == 2);
        if (nm == 2 || nm == 4) e_stat = 2'b11;
        else if (nm == 5)       e_stat = 2'b00;
        else if (intr_busy)     e_stat = 2'b01;
        else if (sync_wait)     e_stat = 2'b10;
        else                    e_stat = 2'b00;
        if (!e_drive || nm == 5 || idle_cycle) begin e_addr = '1; e_rw = 1; end
        else begin e_addr = core_addr; e_rw = core_rw; end
    endtask

    task automatic compare_all();
        chk(addr_oe == e_drive && data_oe == e_drive && rw_oe == e_drive, "R2 enables",
            {29'd0, addr_oe, data_oe, rw_oe}, {29'd0, e_drive, e_drive, e_drive});
        chk(addr_out == e_addr && rw_out == e_rw, "R6 addr/rw", {15'd0, rw_out, addr_out}, {15'd0, e_rw, e_addr});
        chk({ba, bs} == e_stat, "R7 status", {30'd0, ba, bs}, {30'd0, e_stat});
        chk(clk_freeze == e_freeze, "R5 freeze", {31'd0, clk_freeze}, {31'd0, e_freeze});
        chk(int_block == e_intblk, "R3 int_block", {31'd0, int_block}, {31'd0, e_intblk});
    endtask

    // one clock: new core address, edge, model update, sample at falling edge
    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            core_addr = core_addr * 16'd5 + 16'd7;
            core_rw   = core_addr[3];
            @(posedge clk);
            model_edge();
            @(negedge clk);
            compare_all();
        end
    endtask

    initial begin
        rst_n = 0; halt_n = 1; dma_req_n = 1; instr_end = 0; idle_cycle = 0;
        intr_busy = 0; sync_wait = 0; core_rw = 1; core_addr = 16'h1234;
        @(negedge clk);
        step(2);
        // R10 reset state
        chk(addr_oe && addr_out == 16'hFFFF && rw_out && {ba, bs} == 2'b01 && !clk_freeze,
            "R10 reset", {addr_oe, ba, bs, addr_out}, {1'b1, 2'b01, 16'hFFFF});
        rst_n = 1;
        step(3);

        // R6: idle cycles force all ones
        idle_cycle = 1; step(2);
        chk(addr_out == 16'hFFFF && rw_out, "R6 idle forced", {15'd0, rw_out, addr_out}, 32'h1FFFF);
        idle_cycle = 0; step(2);

        // R7: status encodings with priority
        sync_wait = 1; step(1);
        chk({ba, bs} == 2'b10, "R7 sync", {ba, bs}, 2'b10);
        intr_busy = 1; step(1);
        chk({ba, bs} == 2'b01, "R7 intr over sync", {ba, bs}, 2'b01);
        intr_busy = 0; sync_wait = 0; step(1);

        // R1: halt waits for end of instruction
        halt_n = 0; step(4);
        chk(addr_oe == 1'b1, "R1 halt pending keeps bus", addr_oe, 1);
        instr_end = 1; step(1); instr_end = 0;
        chk(addr_oe == 1'b0 && int_block, "R1 halted after end", {addr_oe, int_block}, 2'b01);
        step(5);
        // R3: halted keeps clocks running
        chk(!clk_freeze, "R3 no freeze while halted", clk_freeze, 0);
        halt_n = 1; step(2);
        // R1: cancelled pending halt
        halt_n = 0; step(2); halt_n = 1; step(1);
        chk(addr_oe, "R1 cancelled pending halt", addr_oe, 1);
        step(1);

        // R4 / R5: grant latency and refresh stealing
        dma_req_n = 0; step(1);
        chk(addr_oe && clk_freeze, "R4 first edge", {addr_oe, clk_freeze}, 2'b11);
        step(1);
        chk(!addr_oe && {ba, bs} == 2'b11, "R4 granted", {addr_oe, ba, bs}, 3'b011);
        step(SP - 1);
        chk(!addr_oe, "R5 still granted at cycle 14", addr_oe, 0);
        step(1);
        chk(addr_oe && addr_out == 16'hFFFF && rw_out && !clk_freeze && {ba, bs} == 2'b00,
            "R5 refresh cycle", {addr_oe, clk_freeze, ba, bs, addr_out}, {4'b1000, 16'hFFFF});
        step(1);
        chk(!addr_oe && clk_freeze, "R5 grant resumes", {addr_oe, clk_freeze}, 2'b01);
        step(2 * SP + 3);
        // R9: release
        dma_req_n = 1; sync_wait = 1; step(1);
        chk(addr_oe && !clk_freeze && {ba, bs} == 2'b10, "R9 release", {addr_oe, clk_freeze, ba, bs}, 4'b1010);
        sync_wait = 0; step(2);

        // R8: both requests together, bus request wins
        halt_n = 0; dma_req_n = 0; step(1);
        chk(clk_freeze && !int_block, "R8 dma first", {clk_freeze, int_block}, 2'b10);
        step(1);
        chk(!addr_oe && !int_block && {ba, bs} == 2'b11, "R8 granted not halted", {addr_oe, int_block}, 2'b00);
        step(5);
        dma_req_n = 1; step(1);
        chk(addr_oe, "R9 release with halt held", addr_oe, 1);
        step(3);
        instr_end = 1; step(1); instr_end = 0; step(2);
        // R4 from halted
        dma_req_n = 0; step(1);
        chk(addr_oe && clk_freeze && !int_block, "R4 from halted", {addr_oe, clk_freeze, int_block}, 3'b110);
        step(SP + 4);
        dma_req_n = 1; halt_n = 1; step(3);

        // mixed traffic
        for (int k = 0; k < 60; k++) begin
            idle_cycle = (k % 5 == 2);
            instr_end  = (k % 3 == 0);
            intr_busy  = (k % 11 == 4);
            sync_wait  = (k % 7 == 1);
            halt_n     = !(k >= 10 && k < 25);
            dma_req_n  = !(k >= 30 && k < 50);
            step(1);
        end

        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule